// File: doc/BRIEF.md
# Interrupt Acceptance and Exception Entry Unit

This unit sits beside the instruction sequencer of a small processor core. At every instruction boundary it looks at four request sources: a 4-bit encoded external level, a level-driven pin request with its own event code, a peripheral request whose level and code come from a separate interrupt controller, and a debug-port interrupt. It decides whether one of them may interrupt the running program, and if so it carries out the hardware part of exception entry.

On acceptance the unit captures the return address and the old status word. It loads both event-code registers and returns a status word with the block, privileged-mode and bank bits raised. It also pulses a redirect request towards the fetch unit, with the handler address taken from the vector base. The core feeds the live status word back each cycle, so the status output follows the status input whenever nothing is accepted.

All outputs are registered, and each shows the effect of a boundary one clock edge after that boundary is sampled. The active-low reset is asynchronous on assertion and is released through a two-stage synchronizer.

Top module: `irq_entry_ctrl`

## Requirements
- R1: With `boundary_i` low nothing is accepted: `redirect_o` stays 0 in the following cycle and the saved-PC, saved-status and event-code outputs keep their values.
- R2: With status bit 28 (block bit) set in `sr_i`, no source is accepted.
- R3: A source is eligible only when its level is strictly greater than the mask in `sr_i[7:4]`. A mask equal to the level blocks it, and a level of 0 is never accepted.
- R4: On acceptance `spc_o` takes `next_pc_i` and `ssr_o` takes the whole of `sr_i` as sampled at that boundary.
- R5: An external level L other than 4'hF requests at level L, and on its acceptance both event-code outputs become 12'h200 + L*12'h20. An external level of 4'hF means no request.
- R6: The debug request counts as level 15. It is accepted whenever the mask is below 15, and it loads 12'h5E0 into both event-code outputs.
- R7: On acceptance of a pin or peripheral request, both event-code outputs take that source's supplied code.
- R8: `sr_o` equals `sr_i` of the previous cycle. After an acceptance, bits 28, 29 and 30 are also set to 1, and the mask in bits 7:4 is left at its old value.
- R9: `redirect_o` is high for exactly the cycle after an acceptance, and `target_o` then equals `vbr_i` (as sampled) + 32'h600.
- R10: When several sources are eligible, the highest level wins. Ties are broken in the fixed order debug, external, pin, peripheral.
- R11: The saved-PC, saved-status, event-code and target outputs change only on acceptance.
- R12: While reset is applied, `spc_o`, `ssr_o`, both event codes and `target_o` are 0, `redirect_o` is 0 and `sr_o` is 32'h700000F0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ext_level_i | input | 4 | Encoded external level, 4'hF = none |
| pin_req_i | input | 1 | Pin request active |
| pin_level_i | input | 4 | Pin request priority level |
| pin_code_i | input | 12 | Pin request event code |
| per_req_i | input | 1 | Peripheral request active |
| per_level_i | input | 4 | Peripheral request priority level |
| per_code_i | input | 12 | Peripheral request event code |
| dbg_req_i | input | 1 | Debug-port interrupt request |
| sr_i | input | 32 | Current status word |
| next_pc_i | input | 32 | Address of the instruction after the current one |
| vbr_i | input | 32 | Vector base address |
| spc_o | output | 32 | Saved return address |
| ssr_o | output | 32 | Saved status word |
| evt_code_o | output | 12 | Event code, first copy |
| evt_code2_o | output | 12 | Event code, second copy |
| sr_o | output | 32 | Updated status word |
| redirect_o | output | 1 | One-cycle redirect request |
| target_o | output | 32 | Handler address |

## Verification
The assertions assume that every input is known and settled at the sampling edge. They also assume `sr_i`, `next_pc_i` and `vbr_i` are the values the core means for that very boundary, because saved values are compared with `$past` of those inputs. The bench changes inputs only on the falling clock edge, drives every field from a vector table with defined values, and keeps each supplied event code within 12 bits. Back-to-back vectors may both be accepted, so the assertions make no claim that two redirect pulses are separated by an idle cycle.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
  localparam int LVL_W   = 4;
  localparam int CODE_W  = 12;
  localparam int NUM_SRC = 4;

  // index order is also the tie-break order (lower index wins)
  localparam int SRC_DBG = 0;
  localparam int SRC_EXT = 1;
  localparam int SRC_PIN = 2;
  localparam int SRC_PER = 3;

  typedef struct packed {
    logic              req;
    logic [LVL_W-1:0]  lvl;
    logic [CODE_W-1:0] code;
  } irq_cand_t;
endpackage

// File: rtl/irq_src_map.sv
module irq_src_map
  import irq_entry_pkg::*;
#(
  parameter int EXT_BASE = 'h200,
  parameter int EXT_STEP = 'h20,
  parameter int DBG_CODE = 'h5E0
) (
  input  logic [LVL_W-1:0]  ext_level_i,
  input  logic              pin_req_i,
  input  logic [LVL_W-1:0]  pin_level_i,
  input  logic [CODE_W-1:0] pin_code_i,
  input  logic              per_req_i,
  input  logic [LVL_W-1:0]  per_level_i,
  input  logic [CODE_W-1:0] per_code_i,
  input  logic              dbg_req_i,
  output irq_cand_t         cand_o [NUM_SRC]
);
  localparam logic [LVL_W-1:0] LVL_MAX = {LVL_W{1'b1}};

  always_comb begin
    cand_o[SRC_DBG].req  = dbg_req_i;
    cand_o[SRC_DBG].lvl  = LVL_MAX;
    cand_o[SRC_DBG].code = CODE_W'(DBG_CODE);

    // all-ones encoding is the idle value of the external level
    cand_o[SRC_EXT].req  = (ext_level_i != LVL_MAX);
    cand_o[SRC_EXT].lvl  = ext_level_i;
    cand_o[SRC_EXT].code = CODE_W'(EXT_BASE) + CODE_W'(ext_level_i) * CODE_W'(EXT_STEP);

    cand_o[SRC_PIN].req  = pin_req_i;
    cand_o[SRC_PIN].lvl  = pin_level_i;
    cand_o[SRC_PIN].code = pin_code_i;

    cand_o[SRC_PER].req  = per_req_i;
    cand_o[SRC_PER].lvl  = per_level_i;
    cand_o[SRC_PER].code = per_code_i;
  end
endmodule

// File: rtl/irq_qualify_sel.sv
module irq_qualify_sel
  import irq_entry_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MASK_LSB = 4,
  parameter int BL_BIT   = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  irq_cand_t         cand_i [NUM_SRC],
  input  logic [DATA_W-1:0] sr_i,
  input  logic              boundary_i,
  output logic              take_o,
  output logic [CODE_W-1:0] code_o
);
  logic [LVL_W-1:0]   mask;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;
  logic [LVL_W-1:0]   best_lvl;
  logic               found;

  assign mask = sr_i[MASK_LSB +: LVL_W];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
    assign elig[g] = cand_i[g].req && (cand_i[g].lvl > mask);
  end

  // linear scan: strictly greater replaces, so earlier index keeps a tie
  always_comb begin
    grant    = '0;
    best_lvl = '0;
    found    = 1'b0;
    code_o   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && (!found || cand_i[i].lvl > best_lvl)) begin
        grant    = '0;
        grant[i] = 1'b1;
        best_lvl = cand_i[i].lvl;
        code_o   = cand_i[i].code;
        found    = 1'b1;
      end
    end
  end

  assign take_o = boundary_i && !sr_i[BL_BIT] && found;

  assert_single_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_level_above_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> (best_lvl > mask));
endmodule

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_entry_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          BL_BIT  = 28,
  parameter int          RB_BIT  = 29,
  parameter int          MD_BIT  = 30,
  parameter int          VEC_OFF = 'h600,
  parameter logic [31:0] SR_RST  = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [DATA_W-1:0] sr_i,
  input  logic [DATA_W-1:0] next_pc_i,
  input  logic [DATA_W-1:0] vbr_i,
  output logic [DATA_W-1:0] spc_o,
  output logic [DATA_W-1:0] ssr_o,
  output logic [CODE_W-1:0] evt_o,
  output logic [CODE_W-1:0] evt2_o,
  output logic [DATA_W-1:0] sr_o,
  output logic              redirect_o,
  output logic [DATA_W-1:0] target_o
);
  logic [DATA_W-1:0] entry_bits;
  logic [DATA_W-1:0] sr_d;
  logic [DATA_W-1:0] tgt_d;

  always_comb begin
    entry_bits         = '0;
    entry_bits[BL_BIT] = 1'b1;
    entry_bits[RB_BIT] = 1'b1;
    entry_bits[MD_BIT] = 1'b1;
    sr_d  = take_i ? (sr_i | entry_bits) : sr_i;
    tgt_d = vbr_i + DATA_W'(VEC_OFF);
  end

  // capture registers: clock enable is the acceptance strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spc_o    <= '0;
      ssr_o    <= '0;
      evt_o    <= '0;
      evt2_o   <= '0;
      target_o <= '0;
    end else if (take_i) begin
      spc_o    <= next_pc_i;
      ssr_o    <= sr_i;
      evt_o    <= code_i;
      evt2_o   <= code_i;
      target_o <= tgt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_o       <= DATA_W'(SR_RST);
      redirect_o <= 1'b0;
    end else begin
      sr_o       <= sr_d;
      redirect_o <= take_i;
    end
  end
endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_entry_pkg::*;
#(
  parameter int          DATA_W   = 32,
  parameter int          MASK_LSB = 4,
  parameter int          BL_BIT   = 28,
  parameter int          RB_BIT   = 29,
  parameter int          MD_BIT   = 30,
  parameter int          VEC_OFF  = 'h600,
  parameter int          EXT_BASE = 'h200,
  parameter int          EXT_STEP = 'h20,
  parameter int          DBG_CODE = 'h5E0,
  parameter logic [31:0] SR_RST   = 32'h7000_00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boundary_i,
  input  logic [3:0]        ext_level_i,
  input  logic              pin_req_i,
  input  logic [3:0]        pin_level_i,
  input  logic [11:0]       pin_code_i,
  input  logic              per_req_i,
  input  logic [3:0]        per_level_i,
  input  logic [11:0]       per_code_i,
  input  logic              dbg_req_i,
  input  logic [31:0]       sr_i,
  input  logic [31:0]       next_pc_i,
  input  logic [31:0]       vbr_i,
  output logic [31:0]       spc_o,
  output logic [31:0]       ssr_o,
  output logic [11:0]       evt_code_o,
  output logic [11:0]       evt_code2_o,
  output logic [31:0]       sr_o,
  output logic              redirect_o,
  output logic [31:0]       target_o
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  irq_cand_t         cand [NUM_SRC];
  logic              take;
  logic [CODE_W-1:0] sel_code;

  // assert asynchronously, release after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  irq_src_map #(
    .EXT_BASE(EXT_BASE), .EXT_STEP(EXT_STEP), .DBG_CODE(DBG_CODE)
  ) u_map (
    .ext_level_i(ext_level_i),
    .pin_req_i  (pin_req_i),
    .pin_level_i(pin_level_i),
    .pin_code_i (pin_code_i),
    .per_req_i  (per_req_i),
    .per_level_i(per_level_i),
    .per_code_i (per_code_i),
    .dbg_req_i  (dbg_req_i),
    .cand_o     (cand)
  );

  irq_qualify_sel #(
    .DATA_W(DATA_W), .MASK_LSB(MASK_LSB), .BL_BIT(BL_BIT)
  ) u_sel (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .cand_i    (cand),
    .sr_i      (sr_i),
    .boundary_i(boundary_i),
    .take_o    (take),
    .code_o    (sel_code)
  );

  irq_entry_regs #(
    .DATA_W(DATA_W), .BL_BIT(BL_BIT), .RB_BIT(RB_BIT), .MD_BIT(MD_BIT),
    .VEC_OFF(VEC_OFF), .SR_RST(SR_RST)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .take_i    (take),
    .code_i    (sel_code),
    .sr_i      (sr_i),
    .next_pc_i (next_pc_i),
    .vbr_i     (vbr_i),
    .spc_o     (spc_o),
    .ssr_o     (ssr_o),
    .evt_o     (evt_code_o),
    .evt2_o    (evt_code2_o),
    .sr_o      (sr_o),
    .redirect_o(redirect_o),
    .target_o  (target_o)
  );

  assert_no_boundary_no_take_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !boundary_i |=> !redirect_o);
  assert_block_bit_gates_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    sr_i[BL_BIT] |=> !redirect_o);
  assert_saved_context_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect_o |-> (spc_o == $past(next_pc_i)) && (ssr_o == $past(sr_i)));
  assert_debug_taken_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (boundary_i && dbg_req_i && !sr_i[BL_BIT] && (sr_i[MASK_LSB +: 4] != 4'hF))
      |=> redirect_o);
  assert_status_entry_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect_o |-> sr_o[BL_BIT] && sr_o[RB_BIT] && sr_o[MD_BIT] &&
                   (sr_o[MASK_LSB +: 4] == $past(sr_i[MASK_LSB +: 4])));
  assert_target_addr_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    redirect_o |-> (target_o == $past(vbr_i) + 32'(VEC_OFF)));
  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_int_n)
    !boundary_i |=> $stable(spc_o) && $stable(ssr_o) && $stable(evt_code_o) &&
                    $stable(evt_code2_o) && $stable(target_o));
endmodule

// File: tb/irq_entry_ctrl_tb.sv
module irq_entry_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary_i;
  logic [3:0]  ext_level_i;
  logic        pin_req_i;
  logic [3:0]  pin_level_i;
  logic [11:0] pin_code_i;
  logic        per_req_i;
  logic [3:0]  per_level_i;
  logic [11:0] per_code_i;
  logic        dbg_req_i;
  logic [31:0] sr_i, next_pc_i, vbr_i;
  logic [31:0] spc_o, ssr_o, sr_o, target_o;
  logic [11:0] evt_code_o, evt_code2_o;
  logic        redirect_o;

  always #10 clk = ~clk; // 50 MHz

  irq_entry_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .ext_level_i(ext_level_i),
    .pin_req_i(pin_req_i), .pin_level_i(pin_level_i), .pin_code_i(pin_code_i),
    .per_req_i(per_req_i), .per_level_i(per_level_i), .per_code_i(per_code_i),
    .dbg_req_i(dbg_req_i), .sr_i(sr_i), .next_pc_i(next_pc_i), .vbr_i(vbr_i),
    .spc_o(spc_o), .ssr_o(ssr_o), .evt_code_o(evt_code_o), .evt_code2_o(evt_code2_o),
    .sr_o(sr_o), .redirect_o(redirect_o), .target_o(target_o)
  );

  typedef struct packed {
    logic        bnd;
    logic [3:0]  ext;
    logic        preq;
    logic [3:0]  plvl;
    logic [11:0] pcode;
    logic        qreq;
    logic [3:0]  qlvl;
    logic [11:0] qcode;
    logic        dbg;
    logic [31:0] sr;
    logic        take;
    logic [11:0] code;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // bnd ext preq plvl pcode  qreq qlvl qcode  dbg sr            take code    req
    '{1'b0, 4'h5, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0000, 1'b0, 12'h000, 8'd1},
    '{1'b1, 4'h5, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0040, 1'b1, 12'h2A0, 8'd5},
    '{1'b1, 4'h5, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0050, 1'b0, 12'h000, 8'd3},
    '{1'b1, 4'h5, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b0, 32'h1000_0000, 1'b0, 12'h000, 8'd2},
    '{1'b1, 4'hF, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0000, 1'b0, 12'h000, 8'd5},
    '{1'b1, 4'hF, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b1, 32'h0000_00E0, 1'b1, 12'h5E0, 8'd6},
    '{1'b1, 4'hF, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b1, 32'h0000_00F0, 1'b0, 12'h000, 8'd6},
    '{1'b1, 4'hF, 1'b1, 4'h7, 12'h600, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0000, 1'b1, 12'h600, 8'd7},
    '{1'b1, 4'hF, 1'b1, 4'h3, 12'h640, 1'b1, 4'h9, 12'h420, 1'b0, 32'h0000_0000, 1'b1, 12'h420, 8'd10},
    '{1'b1, 4'h8, 1'b1, 4'h8, 12'h600, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0000, 1'b1, 12'h300, 8'd10},
    '{1'b1, 4'hF, 1'b1, 4'hF, 12'h620, 1'b0, 4'h0, 12'h000, 1'b1, 32'h0000_0000, 1'b1, 12'h5E0, 8'd10},
    '{1'b1, 4'hF, 1'b1, 4'h0, 12'h660, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0000, 1'b0, 12'h000, 8'd3},
    '{1'b1, 4'h1, 1'b0, 4'h0, 12'h000, 1'b0, 4'h0, 12'h000, 1'b0, 32'h0000_0301, 1'b1, 12'h220, 8'd8},
    '{1'b1, 4'hE, 1'b0, 4'h0, 12'h000, 1'b1, 4'hE, 12'h4A0, 1'b0, 32'h0000_0000, 1'b1, 12'h3C0, 8'd7}
  };

  int n_chk = 0, n_fail = 0;
  logic [31:0] e_spc, e_ssr, e_tgt, e_sr;
  logic [11:0] e_code;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk_all(input string tag, input logic exp_redir);
    chk({tag, " redirect R9"}, {31'd0, redirect_o}, {31'd0, exp_redir});
    chk({tag, " spc R4/R11"}, spc_o, e_spc);
    chk({tag, " ssr R4/R11"}, ssr_o, e_ssr);
    chk({tag, " evt R5/R6/R7"}, {20'd0, evt_code_o}, {20'd0, e_code});
    chk({tag, " evt2 R5/R6/R7"}, {20'd0, evt_code2_o}, {20'd0, e_code});
    chk({tag, " target R9"}, target_o, e_tgt);
    chk({tag, " sr R8"}, sr_o, e_sr);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; boundary_i = 0; ext_level_i = 4'hF; pin_req_i = 0; pin_level_i = 0;
    pin_code_i = 0; per_req_i = 0; per_level_i = 0; per_code_i = 0; dbg_req_i = 0;
    sr_i = 0; next_pc_i = 0; vbr_i = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    e_spc = 0; e_ssr = 0; e_tgt = 0; e_code = 0; e_sr = 32'h7000_00F0;
    chk_all("reset R12", 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e_sr = 32'h0000_0000;
    chk("after release sr R8", sr_o, e_sr);

    for (int i = 0; i < NV; i++) begin
      boundary_i  = VEC[i].bnd;  ext_level_i = VEC[i].ext;
      pin_req_i   = VEC[i].preq; pin_level_i = VEC[i].plvl; pin_code_i = VEC[i].pcode;
      per_req_i   = VEC[i].qreq; per_level_i = VEC[i].qlvl; per_code_i = VEC[i].qcode;
      dbg_req_i   = VEC[i].dbg;  sr_i = VEC[i].sr;
      next_pc_i   = 32'h0000_1000 + 32'(i) * 4;
      vbr_i       = 32'h8000_0000 + 32'(i) * 32'h100;
      if (VEC[i].take) begin
        e_spc = next_pc_i; e_ssr = sr_i; e_code = VEC[i].code;
        e_tgt = vbr_i + 32'h600;
        e_sr  = sr_i | 32'h7000_0000;
      end else begin
        e_sr  = sr_i;
      end
      @(posedge clk); @(negedge clk);
      chk_all($sformatf("vec%0d R%0d", i, VEC[i].req), VEC[i].take);
    end

    // R1: take, then hold the boundary low with a request pending
    boundary_i = 1'b0; ext_level_i = 4'h3; pin_req_i = 0; per_req_i = 0; dbg_req_i = 0;
    sr_i = 32'h0000_0000; next_pc_i = 32'h0000_BEEC; vbr_i = 32'h0000_4000;
    e_sr = 32'h0000_0000;
    @(posedge clk); @(negedge clk);
    chk_all("no boundary R1", 1'b0);
    @(posedge clk); @(negedge clk);
    chk_all("no boundary hold R11", 1'b0);

    // R9: a single accepted boundary gives exactly one pulse
    boundary_i = 1'b1; ext_level_i = 4'h2;
    e_spc = next_pc_i; e_ssr = sr_i; e_code = 12'h240; e_tgt = 32'h0000_4600;
    e_sr = 32'h7000_0000;
    @(posedge clk); @(negedge clk);
    chk_all("single take R9", 1'b1);
    boundary_i = 1'b0; e_sr = 32'h0000_0000;
    @(posedge clk); @(negedge clk);
    chk_all("pulse ends R9", 1'b0);

    // R12 asynchronous reset in mid-run
    rst_n = 1'b0; #1;
    e_spc = 0; e_ssr = 0; e_tgt = 0; e_code = 0; e_sr = 32'h7000_00F0;
    chk_all("async reset R12", 1'b0);
    summary();
  end
endmodule